// File: doc/BRIEF.md
# Function Power State Access Gate

This block sits between a host bus target and one peripheral function and applies the rules of a two-state power field (full-on D0, off D3). Each incoming access carries a space code that marks it as configuration, memory or I/O. In D0 every valid access of those three kinds goes to the function. In D3 only configuration accesses go through. Memory and I/O accesses end at once with a master abort, and the function never sees them.

The power field is written by a configuration write to one parameterised address, with the new state in the low two data bits. The gate also holds the interrupt output low while in D3. Status still pending when the field returns to D0 shows up on the interrupt again with no other action. A quiesce output tells the port logic to treat the link as having no device attached and to drop to minimum power for as long as the function is in D3.

Top module: `pm_access_gate`

## Requirements
- R1: A synchronous active-low reset places the power field in D0 (code 00) and drives `port_quiesce` low.
- R2: A valid configuration write (`req_space` 00, `req_write` 1) to address `PS_ADDR` with `req_wdata[1:0]` equal to 00 (D0) or 11 (D3) loads that code into `pstate` at the next clock edge. Writes to any other address leave `pstate` unchanged.
- R3: A power field write carrying code 01 or 10 is ignored, and `pstate` keeps its value.
- R4: In D0, a valid access with `req_space` 00 (config), 01 (memory) or 10 (I/O) is forwarded in the same cycle with unchanged space, address, write flag and data, and `req_mabort` stays low.
- R5: In D3, a valid configuration access is still forwarded, and `req_mabort` stays low.
- R6: In D3, a valid memory or I/O access raises `req_mabort` in the same cycle, and `fwd_valid` stays low.
- R7: A valid access with the reserved space code 11 is master-aborted in either power state and is never forwarded.
- R8: In D0, `irq_out` is high exactly when some bit is set in both `irq_pending` and `irq_enable`.
- R9: In D3, `irq_out` is low whatever the pending and enable bits are.
- R10: Status still pending and enabled when a write returns the field to D0 raises `irq_out` in the cycle after that write.
- R11: `port_quiesce` is high exactly while `pstate` is D3.
- R12: While `req_valid` is low, neither `fwd_valid` nor `req_mabort` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access present this cycle |
| req_space | input | 2 | Space code: 00 config, 01 memory, 10 I/O, 11 reserved |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| req_mabort | output | 1 | Access ends with a master abort this cycle |
| fwd_valid | output | 1 | Access forwarded to the function |
| fwd_space | output | 2 | Forwarded space code |
| fwd_write | output | 1 | Forwarded write flag |
| fwd_addr | output | ADDR_W | Forwarded address |
| fwd_wdata | output | DATA_W | Forwarded write data |
| irq_pending | input | N_IRQ | Interrupt status bits from the function |
| irq_enable | input | N_IRQ | Interrupt enable bits |
| irq_out | output | 1 | Gated interrupt request |
| pstate | output | 2 | Current power field |
| port_quiesce | output | 1 | Port wires may go to the no-device, minimum-power condition |

## Verification
The assertions assume that `req_space`, `req_valid` and the interrupt vectors are known, stable values between clock edges. They also assume that a power field write is a single-cycle configuration access, so the state seen by the decode is always the registered one. The stimulus changes inputs only on the falling edge and holds every access for one full cycle. It moves between states only through that write path, including writes with the unsupported codes, so the properties on the power field never see a value that did not arrive through the configuration decode.

// File: rtl/pmg_pkg.sv
// Shared codes for the power state access gate.
// Assumes a two-bit space code and a two-bit power field.
package pmg_pkg;
    typedef enum logic [1:0] {
        SP_CFG = 2'b00,
        SP_MEM = 2'b01,
        SP_IO  = 2'b10,
        SP_RSV = 2'b11
    } space_e;

    localparam logic [1:0] PS_D0 = 2'b00;
    localparam logic [1:0] PS_D3 = 2'b11;

    // True for the two power codes the field holds.
    function automatic logic ps_code_ok(input logic [1:0] code);
        return (code == PS_D0) || (code == PS_D3);
    endfunction
endpackage

// File: rtl/pmg_pstate_reg.sv
// Holds the power field. Loads only the supported codes (D0, D3).
// Assumes wr_en is a single-cycle strobe from the access decode.
module pmg_pstate_reg
    import pmg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_val,
    output logic [1:0] state,
    output logic       in_d3
);
    logic [1:0] state_q;

    // Register the field; unsupported codes leave it unchanged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_D0;
        end else if (wr_en && ps_code_ok(wr_val)) begin
            state_q <= wr_val;
        end
    end

    assign state = state_q;
    assign in_d3 = (state_q == PS_D3);

    assert_field_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_D0) || (state_q == PS_D3));

    assert_bad_code_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ps_code_ok(wr_val)) |=> $stable(state_q));

    assert_good_code_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ps_code_ok(wr_val)) |=> (state_q == $past(wr_val)));
endmodule

// File: rtl/pmg_access_filter.sv
// Decodes each access by space and either forwards it or master-aborts it
// in the same cycle. Also spots writes to the power field.
// Assumes the request is held for one full cycle.
module pmg_access_filter
    import pmg_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter logic [ADDR_W-1:0] PS_ADDR = 12'h044
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_d3,
    input  logic              req_valid,
    input  logic [1:0]        req_space,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_mabort,
    output logic              fwd_valid,
    output logic [1:0]        fwd_space,
    output logic              fwd_write,
    output logic [ADDR_W-1:0] fwd_addr,
    output logic [DATA_W-1:0] fwd_wdata,
    output logic              ps_wr_en,
    output logic [1:0]        ps_wr_val
);
    logic is_cfg;
    logic is_data_space;
    logic allowed;

    // Classify the access and decide pass or abort.
    always_comb begin
        is_cfg        = (req_space == SP_CFG);
        is_data_space = (req_space == SP_MEM) || (req_space == SP_IO);
        allowed       = is_cfg || (is_data_space && !in_d3);
        fwd_valid     = req_valid && allowed;
        req_mabort    = req_valid && !allowed;
    end

    // Drive the payload only for a forwarded access.
    always_comb begin
        fwd_space = fwd_valid ? req_space : SP_CFG;
        fwd_write = fwd_valid && req_write;
        fwd_addr  = fwd_valid ? req_addr  : '0;
        fwd_wdata = fwd_valid ? req_wdata : '0;
    end

    // Spot a configuration write to the power field.
    always_comb begin
        ps_wr_en  = req_valid && is_cfg && req_write && (req_addr == PS_ADDR);
        ps_wr_val = req_wdata[1:0];
    end

    assert_d3_only_cfg_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && in_d3) |-> (fwd_space == SP_CFG));

    assert_rsv_aborts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_space == SP_RSV) |-> (req_mabort && !fwd_valid));

    assert_one_outcome_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(fwd_valid && req_mabort));

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!fwd_valid && !req_mabort));
endmodule

// File: rtl/pmg_irq_gate.sv
// Combines pending and enable bits into one request and blocks it in D3.
// Pending bits are never cleared here, so they show again on return to D0.
module pmg_irq_gate #(
    parameter int N_IRQ = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_d3,
    input  logic [N_IRQ-1:0] pend,
    input  logic [N_IRQ-1:0] en,
    output logic             irq
);
    logic [N_IRQ-1:0] live;

    // Per-source qualification.
    genvar g;
    generate
        for (g = 0; g < N_IRQ; g++) begin : g_src
            assign live[g] = pend[g] & en[g];
        end
    endgenerate

    // Reduce and gate by power state.
    always_comb begin
        irq = (|live) && !in_d3;
    end

    assert_d3_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_d3 |-> !irq);

    assert_d0_delivers_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_d3 && ((pend & en) != '0)) |-> irq);

    assert_wake_redeliver_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(in_d3) && ((pend & en) != '0)) |-> irq);
endmodule

// File: rtl/pm_access_gate.sv
// Top of the power state access gate: access filter, power field and
// interrupt gate. Assumes one access per cycle from the bus target.
module pm_access_gate
    import pmg_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter int N_IRQ   = 4,
    parameter logic [ADDR_W-1:0] PS_ADDR = 12'h044
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_space,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_mabort,
    output logic              fwd_valid,
    output logic [1:0]        fwd_space,
    output logic              fwd_write,
    output logic [ADDR_W-1:0] fwd_addr,
    output logic [DATA_W-1:0] fwd_wdata,
    input  logic [N_IRQ-1:0]  irq_pending,
    input  logic [N_IRQ-1:0]  irq_enable,
    output logic              irq_out,
    output logic [1:0]        pstate,
    output logic              port_quiesce
);
    logic       in_d3;
    logic       ps_wr_en;
    logic [1:0] ps_wr_val;

    pmg_access_filter #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .PS_ADDR(PS_ADDR)
    ) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_d3     (in_d3),
        .req_valid (req_valid),
        .req_space (req_space),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_mabort(req_mabort),
        .fwd_valid (fwd_valid),
        .fwd_space (fwd_space),
        .fwd_write (fwd_write),
        .fwd_addr  (fwd_addr),
        .fwd_wdata (fwd_wdata),
        .ps_wr_en  (ps_wr_en),
        .ps_wr_val (ps_wr_val)
    );

    pmg_pstate_reg u_pstate (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (ps_wr_en),
        .wr_val(ps_wr_val),
        .state (pstate),
        .in_d3 (in_d3)
    );

    pmg_irq_gate #(
        .N_IRQ(N_IRQ)
    ) u_irq (
        .clk  (clk),
        .rst_n(rst_n),
        .in_d3(in_d3),
        .pend (irq_pending),
        .en   (irq_enable),
        .irq  (irq_out)
    );

    assign port_quiesce = in_d3;

    assert_quiesce_tracks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        port_quiesce |-> (pstate == PS_D3));
endmodule

// File: tb/pm_access_gate_tb_top.sv
module pm_access_gate_tb_top;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int N_IRQ  = 4;
    localparam logic [ADDR_W-1:0] PS_ADDR = 12'h044;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_space = 2'b00;
    logic req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic req_mabort, fwd_valid, fwd_write, irq_out, port_quiesce;
    logic [1:0] fwd_space, pstate;
    logic [ADDR_W-1:0] fwd_addr;
    logic [DATA_W-1:0] fwd_wdata;
    logic [N_IRQ-1:0] irq_pending = '0;
    logic [N_IRQ-1:0] irq_enable = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pm_access_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_IRQ(N_IRQ), .PS_ADDR(PS_ADDR)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_space(req_space), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mabort(req_mabort),
        .fwd_valid(fwd_valid), .fwd_space(fwd_space), .fwd_write(fwd_write),
        .fwd_addr(fwd_addr), .fwd_wdata(fwd_wdata),
        .irq_pending(irq_pending), .irq_enable(irq_enable), .irq_out(irq_out),
        .pstate(pstate), .port_quiesce(port_quiesce)
    );

    // Vector: [15:14] state, [13] valid, [12:11] space, [10:7] pend,
    // [6:3] enable, [2] fwd, [1] abort, [0] irq
    localparam logic [15:0] VEC [12] = '{
        {2'd0, 1'b1, 2'd0, 4'b0001, 4'b0001, 3'b101},
        {2'd0, 1'b1, 2'd1, 4'b0000, 4'b1111, 3'b100},
        {2'd0, 1'b1, 2'd2, 4'b1010, 4'b0010, 3'b101},
        {2'd0, 1'b1, 2'd3, 4'b0000, 4'b0000, 3'b010},
        {2'd0, 1'b0, 2'd1, 4'b1111, 4'b0000, 3'b000},
        {2'd3, 1'b1, 2'd0, 4'b1111, 4'b1111, 3'b100},
        {2'd3, 1'b1, 2'd1, 4'b0001, 4'b0001, 3'b010},
        {2'd3, 1'b1, 2'd2, 4'b0001, 4'b0001, 3'b010},
        {2'd3, 1'b1, 2'd3, 4'b0001, 4'b0001, 3'b010},
        {2'd3, 1'b0, 2'd2, 4'b0001, 4'b0001, 3'b000},
        {2'd0, 1'b1, 2'd1, 4'b0100, 4'b1000, 3'b100},
        {2'd0, 1'b0, 2'd0, 4'b1000, 4'b1000, 3'b001}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        req_valid = 1'b0; req_space = 2'b00; req_write = 1'b0;
        req_addr = '0; req_wdata = '0;
    endtask

    // One-cycle configuration write; returns at the falling edge after the update.
    task automatic cfg_write(input logic [ADDR_W-1:0] a, input logic [1:0] code);
        @(negedge clk);
        req_valid = 1'b1; req_space = 2'b00; req_write = 1'b1;
        req_addr = a; req_wdata = {30'h0, code};
        @(negedge clk);
        idle();
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1 pstate after reset", pstate, 2'b00);
        check("R1 quiesce after reset", port_quiesce, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < 12; i++) begin
            cfg_write(PS_ADDR, VEC[i][15:14]);
            req_valid = VEC[i][13]; req_space = VEC[i][12:11];
            req_write = 1'b0; req_addr = 12'h100 + ADDR_W'(i); req_wdata = 32'hA5A50000 + i;
            irq_pending = VEC[i][10:7]; irq_enable = VEC[i][6:3];
            #1;
            check("R4/R5/R6/R7/R12 fwd_valid", fwd_valid, VEC[i][2]);
            check("R6/R7/R12 req_mabort", req_mabort, VEC[i][1]);
            check("R8/R9 irq_out", irq_out, VEC[i][0]);
            check("R11 port_quiesce", port_quiesce, VEC[i][15:14] == 2'b11);
            if (VEC[i][2]) begin
                check("R4 fwd_addr", fwd_addr, 12'h100 + ADDR_W'(i));
                check("R4 fwd_space", fwd_space, VEC[i][12:11]);
            end
            idle();
        end

        // R2: write to another address leaves the field alone
        cfg_write(PS_ADDR, 2'b00);
        cfg_write(PS_ADDR + 12'h4, 2'b11);
        #1; check("R2 other address ignored", pstate, 2'b00);

        // R3: unsupported codes ignored in both states
        cfg_write(PS_ADDR, 2'b01);
        #1; check("R3 code 01 ignored in D0", pstate, 2'b00);
        cfg_write(PS_ADDR, 2'b11);
        #1; check("R2 enter D3", pstate, 2'b11);
        cfg_write(PS_ADDR, 2'b10);
        #1; check("R3 code 10 ignored in D3", pstate, 2'b11);

        // R4: write payload forwarded in D0
        cfg_write(PS_ADDR, 2'b00);
        req_valid = 1'b1; req_space = 2'b10; req_write = 1'b1;
        req_addr = 12'h3F6; req_wdata = 32'hDEADBEEF;
        #1;
        check("R4 fwd_write", fwd_write, 1'b1);
        check("R4 fwd_wdata", fwd_wdata, 32'hDEADBEEF);
        idle();

        // R10: pending held through D3, delivered after return to D0
        cfg_write(PS_ADDR, 2'b11);
        irq_pending = 4'b0010; irq_enable = 4'b0010;
        #1; check("R9 irq held in D3", irq_out, 1'b0);
        @(negedge clk);
        req_valid = 1'b1; req_space = 2'b00; req_write = 1'b1;
        req_addr = PS_ADDR; req_wdata = 32'h0;
        #1; check("R10 irq low during wake write", irq_out, 1'b0);
        check("R5 wake write forwarded in D3", fwd_valid, 1'b1);
        @(negedge clk);
        idle();
        #1; check("R10 irq after return to D0", irq_out, 1'b1);
        check("R11 quiesce low in D0", port_quiesce, 1'b0);

        // R1: reset from D3
        cfg_write(PS_ADDR, 2'b11);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        check("R1 reset returns D0", pstate, 2'b00);
        check("R1 reset clears quiesce", port_quiesce, 1'b0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule